// File: doc/BRIEF.md
# Legacy Memory Window Decoder

This block steers every memory access below the 1 MB boundary to one of two targets: system DRAM or the bus side (PCI and the devices behind it). The steering comes from configuration bytes that firmware programs through a small byte-wide config port. Seven shadow-attribute bytes cover thirteen ROM-shadow regions. One system-management control byte covers the 128 KB legacy video window.

Each shadow region has an independent read-enable bit and write-enable bit. With these, firmware can copy a ROM into DRAM and then lock the copy read-only. The legacy window is normally claimed by the bus. It can be opened to all code, or shown only to system-management code. Accesses below the legacy window always go to DRAM.

The config write port is registered. The read port and the access decode are combinational, so an access is decoded with the configuration as it stands after the previous clock edge.

Top module: `lw_window_decoder`

## Requirements
- R1: After reset, every shadow byte (config offsets 0x59 to 0x5F) reads 0x00 and the control byte at 0x72 reads 0x02. Every shadow-region access and every non-system-management access to 0xA0000 to 0xBFFFF then goes to the bus (acc_dram = 0).
- R2: Any access with an address below 0xA0000 goes to DRAM, whatever the configuration, the direction or the system-management flag.
- R3: The BIOS region 0xF0000 to 0xFFFFF takes its attribute from bits 5:4 of byte 0x59. Bit 4 sends reads to DRAM and bit 5 sends writes to DRAM; a clear bit sends that direction to the bus.
- R4: Expansion region k (k = 1 to 12) spans 16 KB starting at 0xC0000 + (k-1)*0x4000 and takes its attribute from byte 0x59 + ceil(k/2). An odd k uses bits 1:0 and an even k uses bits 5:4. In each pair the lower bit is the read enable and the upper bit is the write enable.
- R5: The read and write enables of a region act independently: a write to a read-only region goes to the bus, and a read from a write-only region goes to the bus.
- R6: A non-system-management access to 0xA0000 to 0xBFFFF goes to DRAM exactly when bit 6 (open) of byte 0x72 is set.
- R7: A system-management access to 0xA0000 to 0xBFFFF goes to DRAM exactly when bit 3 (global enable) or bit 6 of byte 0x72 is set.
- R8: Bits 2:0 of byte 0x72 always read 010b. Bits 7:3 read back the last value written to them.
- R9: A config write is seen by the read port and by the access decode from the first clock edge that samples it onward. Both paths are combinational on the stored state.
- R10: Writes to any offset other than 0x59 to 0x5F and 0x72 are ignored: such an offset reads 0x00 and the decode is unchanged.
- R11: The system-management flag affects no access outside 0xA0000 to 0xBFFFF.
- R12: Shadow bytes store and read back all eight bits, including the bits that no region uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Config byte write strobe |
| cfg_addr | input | 8 | Config byte offset, used for both write and read |
| cfg_wdata | input | 8 | Config write data |
| cfg_rdata | output | 8 | Config byte at cfg_addr (combinational) |
| acc_addr | input | 20 | Access address |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_smm | input | 1 | Access issued in system-management mode |
| acc_dram | output | 1 | 1 = access targets DRAM, 0 = bus side |

## Verification
The bench builds the block with its default parameters: a 20-bit address, twelve 16 KB expansion regions from 0xC0000, a 64 KB BIOS region and seven attribute bytes. With these values all thirteen regions exist, byte 0x59 serves region 0 alone, and every later byte serves one odd and one even region. Both nibble positions and both region boundaries of each byte can therefore be reached. A behavioural model built on byte offsets and address arithmetic predicts acc_dram and cfg_rdata on every cycle. The stimulus covers sweeps of the whole megabyte with all direction and mode combinations, and mixed-enable patterns. It also writes to neighbouring offsets (0x58, 0x60, 0x71, 0x73) to confirm they have no effect.

// File: rtl/lw_pkg.sv
package lw_pkg;

   typedef enum logic {
      TGT_BUS  = 1'b0,
      TGT_DRAM = 1'b1
   } lw_tgt_e;

   // two-bit shadow attribute: upper bit write enable, lower bit read enable
   typedef struct packed {
      logic wr_en;
      logic rd_en;
   } lw_attr_t;

endpackage

// File: rtl/lw_cfg_regs.sv
module lw_cfg_regs
   import lw_pkg::*;
#(
   parameter int CFG_AW      = 8,
   parameter int ATTR_BASE   = 'h59,
   parameter int ATTR_CNT    = 7,
   parameter int NUM_EXP     = 12,
   parameter int SMC_OFF     = 'h72,
   parameter int SMC_RESET   = 'h02,
   parameter int SMC_RO_MASK = 'h07,
   parameter int OPEN_BIT    = 6,
   parameter int GEN_BIT     = 3,
   localparam int NREG       = NUM_EXP + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [CFG_AW-1:0]     addr,
   input  logic [7:0]            wdata,
   output logic [7:0]            rdata,
   output lw_attr_t [NREG-1:0]   reg_attr,
   output logic                  d_open,
   output logic                  g_en
);

   localparam logic [CFG_AW-1:0] SMC_A   = CFG_AW'(SMC_OFF);
   localparam logic [7:0]        RO_M    = 8'(SMC_RO_MASK);
   localparam logic [7:0]        RST_V   = 8'(SMC_RESET);

   initial begin
      assert (ATTR_BASE + ATTR_CNT <= (1 << CFG_AW))
         else $error("attribute bytes exceed config space");
      assert (SMC_OFF < ATTR_BASE || SMC_OFF >= ATTR_BASE + ATTR_CNT)
         else $error("control byte overlaps attribute bytes");
      assert ((NREG / 2) < ATTR_CNT)
         else $error("too few attribute bytes for region count");
      assert (OPEN_BIT < 8 && GEN_BIT < 8)
         else $error("control bit index out of range");
   end

   logic [ATTR_CNT-1:0][7:0] attr_q;
   logic [7:0]               smc_q;

   for (genvar b = 0; b < ATTR_CNT; b++) begin : g_attr
      localparam logic [CFG_AW-1:0] MY_A = CFG_AW'(ATTR_BASE + b);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      attr_q[b] <= '0;
         else if (wr_en && addr == MY_A)  attr_q[b] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         smc_q <= RST_V;
      else if (wr_en && addr == SMC_A)    smc_q <= (wdata & ~RO_M) | (RST_V & RO_M);
   end

   always_comb begin
      rdata = '0;
      if (addr == SMC_A) rdata = smc_q;
      for (int b = 0; b < ATTR_CNT; b++) begin
         if (addr == CFG_AW'(ATTR_BASE + b)) rdata = attr_q[b];
      end
   end

   // region r reads byte ceil(r/2); region 0 and even regions use the high nibble
   for (genvar r = 0; r < NREG; r++) begin : g_fan
      localparam int BI = (r + 1) / 2;
      if (r % 2 == 0) begin : g_hi
         assign reg_attr[r] = lw_attr_t'(attr_q[BI][5:4]);
      end else begin : g_lo
         assign reg_attr[r] = lw_attr_t'(attr_q[BI][1:0]);
      end
   end

   assign d_open = smc_q[OPEN_BIT];
   assign g_en   = smc_q[GEN_BIT];

endmodule

// File: rtl/lw_shadow_decode.sv
module lw_shadow_decode
   import lw_pkg::*;
#(
   parameter int ADDR_W       = 20,
   parameter int NUM_EXP      = 12,
   parameter int EXP_BASE     = 'hC0000,
   parameter int EXP_SZ_LOG2  = 14,
   parameter int BIOS_BASE    = 'hF0000,
   parameter int BIOS_SZ_LOG2 = 16,
   localparam int NREG        = NUM_EXP + 1
) (
   input  logic [ADDR_W-1:0]   addr,
   input  logic                is_write,
   input  lw_attr_t [NREG-1:0] reg_attr,
   output logic                hit,
   output lw_tgt_e             tgt
);

   initial begin
      assert (EXP_SZ_LOG2 < ADDR_W && BIOS_SZ_LOG2 < ADDR_W)
         else $error("region size exceeds address space");
      assert (EXP_BASE + NUM_EXP * (1 << EXP_SZ_LOG2) <= BIOS_BASE)
         else $error("expansion regions overlap the BIOS region");
   end

   logic [NREG-1:0] hit_v;
   logic [NREG-1:0] en_v;

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      if (r == 0) begin : g_bios
         localparam logic [ADDR_W-1:0] B = ADDR_W'(BIOS_BASE);
         assign hit_v[r] = (addr[ADDR_W-1:BIOS_SZ_LOG2] == B[ADDR_W-1:BIOS_SZ_LOG2]);
      end else begin : g_exp
         localparam logic [ADDR_W-1:0] B = ADDR_W'(EXP_BASE + (r - 1) * (1 << EXP_SZ_LOG2));
         assign hit_v[r] = (addr[ADDR_W-1:EXP_SZ_LOG2] == B[ADDR_W-1:EXP_SZ_LOG2]);
      end
      assign en_v[r] = is_write ? reg_attr[r].wr_en : reg_attr[r].rd_en;
   end

   assign hit = |hit_v;
   assign tgt = (|(hit_v & en_v)) ? TGT_DRAM : TGT_BUS;

endmodule

// File: rtl/lw_smram_decode.sv
module lw_smram_decode
   import lw_pkg::*;
#(
   parameter int ADDR_W      = 20,
   parameter int WIN_BASE    = 'hA0000,
   parameter int WIN_SZ_LOG2 = 17
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              smm,
   input  logic              d_open,
   input  logic              g_en,
   output logic              hit,
   output lw_tgt_e           tgt
);

   localparam logic [ADDR_W-1:0] B = ADDR_W'(WIN_BASE);

   initial begin
      assert (WIN_SZ_LOG2 < ADDR_W) else $error("window size exceeds address space");
      assert ((WIN_BASE % (1 << WIN_SZ_LOG2)) == 0) else $error("window base misaligned");
   end

   logic open_view;

   assign hit       = (addr[ADDR_W-1:WIN_SZ_LOG2] == B[ADDR_W-1:WIN_SZ_LOG2]);
   // management code sees DRAM when its private view is enabled or the window is open
   assign open_view = smm ? (g_en | d_open) : d_open;
   assign tgt       = open_view ? TGT_DRAM : TGT_BUS;

endmodule

// File: rtl/lw_window_decoder.sv
module lw_window_decoder
   import lw_pkg::*;
#(
   parameter int CFG_AW       = 8,
   parameter int ADDR_W       = 20,
   parameter int ATTR_BASE    = 'h59,
   parameter int ATTR_CNT     = 7,
   parameter int NUM_EXP      = 12,
   parameter int EXP_BASE     = 'hC0000,
   parameter int EXP_SZ_LOG2  = 14,
   parameter int BIOS_BASE    = 'hF0000,
   parameter int BIOS_SZ_LOG2 = 16,
   parameter int WIN_BASE     = 'hA0000,
   parameter int WIN_SZ_LOG2  = 17,
   parameter int SMC_OFF      = 'h72,
   parameter int OPEN_BIT     = 6,
   parameter int GEN_BIT      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   input  logic              acc_smm,
   output logic              acc_dram
);

   localparam int NREG = NUM_EXP + 1;
   localparam logic [ADDR_W-1:0] LOW_TOP = ADDR_W'(WIN_BASE);

   lw_attr_t [NREG-1:0] reg_attr;
   logic                d_open, g_en;
   logic                sh_hit, sm_hit;
   lw_tgt_e             sh_tgt, sm_tgt, sel;

   lw_cfg_regs #(
      .CFG_AW(CFG_AW), .ATTR_BASE(ATTR_BASE), .ATTR_CNT(ATTR_CNT),
      .NUM_EXP(NUM_EXP), .SMC_OFF(SMC_OFF), .SMC_RESET('h02),
      .SMC_RO_MASK('h07), .OPEN_BIT(OPEN_BIT), .GEN_BIT(GEN_BIT)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
      .wdata(cfg_wdata), .rdata(cfg_rdata), .reg_attr(reg_attr),
      .d_open(d_open), .g_en(g_en)
   );

   lw_shadow_decode #(
      .ADDR_W(ADDR_W), .NUM_EXP(NUM_EXP), .EXP_BASE(EXP_BASE),
      .EXP_SZ_LOG2(EXP_SZ_LOG2), .BIOS_BASE(BIOS_BASE), .BIOS_SZ_LOG2(BIOS_SZ_LOG2)
   ) u_shadow (
      .addr(acc_addr), .is_write(acc_write), .reg_attr(reg_attr),
      .hit(sh_hit), .tgt(sh_tgt)
   );

   lw_smram_decode #(
      .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_SZ_LOG2(WIN_SZ_LOG2)
   ) u_smram (
      .addr(acc_addr), .smm(acc_smm), .d_open(d_open), .g_en(g_en),
      .hit(sm_hit), .tgt(sm_tgt)
   );

   always_comb begin
      if (sm_hit)                  sel = sm_tgt;
      else if (sh_hit)             sel = sh_tgt;
      else if (acc_addr < LOW_TOP) sel = TGT_DRAM;
      else                         sel = TGT_BUS;
   end

   assign acc_dram = (sel == TGT_DRAM);

endmodule

// File: rtl/lw_window_decoder_chk.sv
module lw_window_decoder_chk
   import lw_pkg::*;
#(
   parameter int CFG_AW      = 8,
   parameter int ADDR_W      = 20,
   parameter int ATTR_BASE   = 'h59,
   parameter int ATTR_CNT    = 7,
   parameter int NUM_EXP     = 12,
   parameter int WIN_BASE    = 'hA0000,
   parameter int WIN_SZ_LOG2 = 17,
   parameter int SMC_OFF     = 'h72,
   parameter int OPEN_BIT    = 6
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         cfg_wr_en,
   input logic [CFG_AW-1:0]            cfg_addr,
   input logic [7:0]                   cfg_wdata,
   input logic [7:0]                   cfg_rdata,
   input logic [ADDR_W-1:0]            acc_addr,
   input logic                         acc_smm,
   input logic                         acc_dram,
   input lw_attr_t [NUM_EXP:0]         reg_attr,
   input logic                         d_open,
   input logic                         g_en
);

   localparam logic [ADDR_W-1:0] WB = ADDR_W'(WIN_BASE);
   logic in_win, other_off;

   assign in_win    = (acc_addr[ADDR_W-1:WIN_SZ_LOG2] == WB[ADDR_W-1:WIN_SZ_LOG2]);
   assign other_off = (cfg_addr != CFG_AW'(SMC_OFF)) &&
                      ((int'(cfg_addr) < ATTR_BASE) || (int'(cfg_addr) >= ATTR_BASE + ATTR_CNT));

   // R2
   a_r2_conv_dram: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_addr < WB) |-> acc_dram);

   // R6
   a_r6_closed_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && !acc_smm && !d_open) |-> !acc_dram);

   // R7
   a_r7_smm_dram: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && acc_smm && (g_en || d_open)) |-> acc_dram);

   // R8
   a_r8_fixed_low: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr == CFG_AW'(SMC_OFF)) |-> (cfg_rdata[2:0] == 3'b010));

   // R9
   a_r9_open_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_en && cfg_addr == CFG_AW'(SMC_OFF)) |=> (d_open == $past(cfg_wdata[OPEN_BIT])));

   // R10
   a_r10_other_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_en && other_off) |=> ($stable(reg_attr) && $stable(d_open) && $stable(g_en)));

endmodule

bind lw_window_decoder lw_window_decoder_chk #(
   .CFG_AW(CFG_AW), .ADDR_W(ADDR_W), .ATTR_BASE(ATTR_BASE), .ATTR_CNT(ATTR_CNT),
   .NUM_EXP(NUM_EXP), .WIN_BASE(WIN_BASE), .WIN_SZ_LOG2(WIN_SZ_LOG2),
   .SMC_OFF(SMC_OFF), .OPEN_BIT(OPEN_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
   .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_addr(acc_addr),
   .acc_smm(acc_smm), .acc_dram(acc_dram), .reg_attr(reg_attr),
   .d_open(d_open), .g_en(g_en)
);

// File: tb/tb_lw_window_decoder.sv
module tb_lw_window_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [7:0]  cfg_addr = 8'h00;
   logic [7:0]  cfg_wdata = 8'h00;
   logic [7:0]  cfg_rdata;
   logic [19:0] acc_addr = '0;
   logic        acc_write = 1'b0;
   logic        acc_smm = 1'b0;
   logic        acc_dram;

   int n_cmp = 0;
   int n_bad = 0;
   bit reset_phase = 1'b1;
   bit wrote_last = 1'b0;
   byte unsigned mdl [256];

   always #4 clk = ~clk;

   lw_window_decoder dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_addr(acc_addr),
      .acc_write(acc_write), .acc_smm(acc_smm), .acc_dram(acc_dram)
   );

   // ---------------- reference model ----------------
   function automatic void mdl_reset();
      foreach (mdl[i]) mdl[i] = 8'h00;
      mdl[8'h72] = 8'h02;
   endfunction

   function automatic bit stored(int a);
      return (a >= 'h59 && a <= 'h5F) || a == 'h72;
   endfunction

   function automatic bit exp_dram(int a, bit wr, bit smm);
      int k, nib;
      byte unsigned b;
      if (a < 'hA0000) return 1'b1;
      if (a < 'hC0000) begin
         if (smm) return mdl[8'h72][6] | mdl[8'h72][3];
         return mdl[8'h72][6];
      end
      if (a >= 'hF0000) begin
         nib = (mdl[8'h59] >> 4) & 3;
      end else begin
         k   = (a - 'hC0000) / 'h4000 + 1;
         b   = mdl[8'h59 + (k + 1) / 2];
         nib = (k % 2 == 1) ? (b & 3) : ((b >> 4) & 3);
      end
      return wr ? nib[1] : nib[0];
   endfunction

   function automatic string acc_tag(int a, bit wr, bit smm);
      int k, nib;
      byte unsigned b;
      if (reset_phase) return "R1";
      if (wrote_last)  return "R9";
      if (a < 'hA0000) return smm ? "R11" : "R2";
      if (a < 'hC0000) return smm ? "R7" : "R6";
      if (smm) return "R11";
      if (a >= 'hF0000) nib = (mdl[8'h59] >> 4) & 3;
      else begin
         k   = (a - 'hC0000) / 'h4000 + 1;
         b   = mdl[8'h59 + (k + 1) / 2];
         nib = (k % 2 == 1) ? (b & 3) : ((b >> 4) & 3);
      end
      if (nib == 1 || nib == 2) return "R5";
      if (wr) return (a >= 'hF0000) ? "R3" : "R4";
      return (a >= 'hF0000) ? "R3" : "R4";
   endfunction

   function automatic string rd_tag(int a);
      if (reset_phase) return "R1";
      if (a == 'h72)   return "R8";
      if (stored(a))   return "R12";
      return "R10";
   endfunction

   initial mdl_reset();

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) mdl_reset();
      else if (cfg_wr_en) begin
         if (cfg_addr >= 8'h59 && cfg_addr <= 8'h5F) mdl[cfg_addr] = cfg_wdata;
         else if (cfg_addr == 8'h72) mdl[8'h72] = {cfg_wdata[7:3], 3'b010};
      end
   end

   // compare on every falling edge
   always @(negedge clk) begin
      bit e;
      byte unsigned er;
      if (rst_n) begin
         e = exp_dram(int'(acc_addr), acc_write, acc_smm);
         n_cmp++;
         if (acc_dram !== e) begin
            n_bad++;
            $display("FAIL %s: acc_dram addr=%05h wr=%0b smm=%0b got %0b exp %0b",
                     acc_tag(int'(acc_addr), acc_write, acc_smm), acc_addr,
                     acc_write, acc_smm, acc_dram, e);
         end
         er = stored(int'(cfg_addr)) ? mdl[cfg_addr] : 8'h00;
         n_cmp++;
         if (cfg_rdata !== er) begin
            n_bad++;
            $display("FAIL %s: cfg_rdata off=%02h got %02h exp %02h",
                     rd_tag(int'(cfg_addr)), cfg_addr, cfg_rdata, er);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
      cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
      step();
      cfg_wr_en = 1'b0;
      wrote_last = 1'b1;   // R9: next cycle sees the new value
      step();
      wrote_last = 1'b0;
   endtask

   task automatic sweep(input int stride, input bit rnd_rd);
      for (int a = 0; a < 'h100000; a += stride) begin
         for (int m = 0; m < 4; m++) begin
            acc_addr  = 20'(a + ($urandom % stride));
            acc_write = m[0];
            acc_smm   = m[1];
            if (rnd_rd) cfg_addr = 8'h58 + 8'($urandom % 28);
            step();
         end
      end
   endtask

   task automatic read_all_cfg();
      for (int o = 0; o < 256; o++) begin
         cfg_addr = 8'(o);
         step();
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      logic [7:0] pats [8] = '{8'h00, 8'h11, 8'h22, 8'h33, 8'h12, 8'h21, 8'h31, 8'hCC};
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1: reset state of config space and decode
      read_all_cfg();
      sweep('h1000, 1'b0);
      reset_phase = 1'b0;

      // R3 R4 R5 R12: uniform patterns on all shadow bytes
      foreach (pats[p]) begin
         for (int b = 'h59; b <= 'h5F; b++) cfg_write(8'(b), pats[p]);
         sweep('h2000, 1'b1);
      end
      // R4: distinct pattern per byte, both nibbles differ
      for (int b = 'h59; b <= 'h5F; b++) cfg_write(8'(b), 8'($urandom));
      sweep('h1000, 1'b1);

      // R6 R7 R8: control byte combinations
      foreach (pats[p]) begin
         logic [7:0] v;
         v = {pats[p][1], pats[p][0], 2'b00, pats[p][4], 3'b101};
         cfg_write(8'h72, v);
         cfg_addr = 8'h72;
         for (int i = 0; i < 32; i++) begin
            acc_addr  = 20'('hA0000 + ($urandom % 'h20000));
            acc_write = i[0];
            acc_smm   = i[1];
            step();
         end
      end
      cfg_write(8'h72, 8'hFF);
      cfg_write(8'h72, 8'h00);

      // R10: neighbouring and far offsets are ignored
      cfg_write(8'h72, 8'h48);
      for (int b = 'h59; b <= 'h5F; b++) cfg_write(8'(b), 8'h31);
      cfg_write(8'h58, 8'hFF);
      cfg_write(8'h60, 8'hFF);
      cfg_write(8'h71, 8'hFF);
      cfg_write(8'h73, 8'hFF);
      cfg_write(8'h00, 8'hFF);
      cfg_write(8'hFF, 8'hFF);
      read_all_cfg();
      sweep('h4000, 1'b0);

      // R2 R11 and mixed: random traffic with interleaved writes
      for (int i = 0; i < 4000; i++) begin
         int sel;
         sel = $urandom % 10;
         cfg_wr_en = (sel < 3);
         cfg_addr  = (sel == 0) ? 8'h72 : 8'h56 + 8'($urandom % 12);
         cfg_wdata = 8'($urandom);
         acc_addr  = 20'($urandom);
         acc_write = 1'($urandom);
         acc_smm   = 1'($urandom);
         step();
      end
      cfg_wr_en = 1'b0;
      step();

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule